// File: doc/BRIEF.md
# Quad-Channel Serial Port Global Register Bank

This block is the shared, device-level register bank that sits beside four serial-port channels. It answers a small register window of five dwords, from byte offset 0x080 up to 0x093, and accepts byte, 16-bit or 32-bit accesses. Four active-low byte-lane enables select which bytes of a dword take part in an access.

The bank gathers the four per-channel interrupt lines into one status dword and one combined interrupt output. It holds the control byte and 16-bit reload value of a general-purpose timer, the per-channel 8x-sampling and sleep enables, and a write-only control byte. It also turns writes to a channel-reset byte into single-cycle reset pulses, one per channel. Two bytes are fixed: a revision byte and a device identification byte.

The counting timer, the channels themselves and the bus protocol in front of the request port live elsewhere. A host-side bus engine presents one request per cycle on the `req_*` port. It takes read data from `rsp_rdata` one cycle later.

Top module: `uglb_regs`

## Requirements
- R1: After reset, every register output is 0, the revision byte reads 0x02 and the identification byte reads 0x24.
- R2: A read of dword 0x080 returns the channel interrupt inputs in bits [3:0], sampled at the request edge, with bits [31:4] at 0.
- R3: `irq_any_o` is 1 exactly in the cycle after a cycle in which any bit of `chan_irq_i` was 1.
- R4: Dword 0x084 is read/write with timer control in lane 0, a reserved lane 1, the reload low byte in lane 2 and the reload high byte in lane 3. The reload value and control byte drive `timer_reload_o` and `timer_ctrl_o`.
- R5: A byte lane k takes part in an access only when `req_be_n[k]` is 0. Disabled lanes are not written and read as 0.
- R6: Lane 0 of dword 0x088 holds the per-channel 8x-sampling enables in bits [3:0]. It is read/write, and its bits [7:4] read 0 and are never stored.
- R7: Writing 1 to bit n (n = 0..3) of lane 2 of dword 0x088 makes `chan_rst_o[n]` 1 for exactly the one cycle after the write edge. That lane always reads 0x00.
- R8: Lane 3 of dword 0x088 holds the per-channel sleep enables in bits [3:0]. It is read/write and drives `sleep_o`, and its upper bits read 0.
- R9: Dword 0x08C is read-only apart from lane 2: lane 0 is the revision byte and lane 1 the identification byte, and both ignore writes. Lane 2 is a write-only control byte that drives `aux_ctrl_o` and reads 0x00. Lane 3 is reserved.
- R10: Reserved lanes, dword 0x090, dword 0x080 on writes, any offset outside 0x080 to 0x093 and any offset with bits [1:0] non-zero all ignore writes and read 0.
- R11: `rsp_rdata` carries read data one cycle after a read request. It is 0 in the cycle after a write or idle cycle, and reads never change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the addressed dword |
| req_be_n | input | 4 | Active-low byte-lane enables |
| req_wdata | input | 32 | Write data, lane k in bits [8k+7:8k] |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| chan_irq_i | input | 4 | Per-channel interrupt lines |
| irq_any_o | output | 1 | Combined interrupt |
| timer_ctrl_o | output | 8 | Timer control byte |
| timer_reload_o | output | 16 | Timer reload value |
| x8_mode_o | output | 4 | Per-channel 8x-sampling enables |
| sleep_o | output | 4 | Per-channel sleep enables |
| chan_rst_o | output | 4 | Per-channel one-cycle reset pulses |
| aux_ctrl_o | output | 8 | Write-only control byte |

## Verification
Every result of this bank is registered once. Register outputs, reset pulses, `irq_any_o` and read data all change at the clock edge that samples the request, so each is due exactly one cycle after its stimulus. The bench drives requests on the falling edge and steps to the next falling edge to check, which puts each sample half a cycle after the edge that updates it. The reset pulse gets a second check one cycle later to confirm it has dropped. The combined interrupt is checked both before and after the edge that registers it.

// File: rtl/uglb_pkg.sv
package uglb_pkg;
    localparam int unsigned N_CH    = 4;
    localparam int unsigned DW      = 32;
    localparam int unsigned AW      = 8;
    localparam int unsigned NB      = DW / 8;
    localparam int unsigned IDX_W   = AW - 2;

    localparam logic [IDX_W-1:0] IDX_IRQ  = 6'h20;
    localparam logic [IDX_W-1:0] IDX_TMR  = 6'h21;
    localparam logic [IDX_W-1:0] IDX_AUX  = 6'h22;
    localparam logic [IDX_W-1:0] IDX_ID   = 6'h23;
    localparam logic [IDX_W-1:0] IDX_MPIO = 6'h24;

    localparam logic [7:0] REV_BYTE   = 8'h02;
    localparam logic [7:0] DEVID_BYTE = 8'h24;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IRQ,
        SEL_TMR,
        SEL_AUX,
        SEL_ID,
        SEL_MPIO
    } dw_sel_e;

    typedef struct packed {
        logic [7:0]      tmr_ctrl;
        logic [15:0]     tmr_reload;
        logic [N_CH-1:0] x8;
        logic [N_CH-1:0] sleep;
        logic [N_CH-1:0] chrst;
        logic [7:0]      wo_ctrl;
        logic            irq_any;
        logic [DW-1:0]   rdata;
    } regs_t;
endpackage

// File: rtl/uglb_decode.sv
module uglb_decode
    import uglb_pkg::*;
(
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [NB-1:0] req_be_n,
    output dw_sel_e       sel,
    output logic [NB-1:0] wr_strb,
    output logic          rd_en
);
    logic aligned;

    always_comb begin
        aligned = (req_addr[1:0] == 2'b00);
        sel     = SEL_NONE;
        if (aligned) begin
            unique case (req_addr[AW-1:2])
                IDX_IRQ:  sel = SEL_IRQ;
                IDX_TMR:  sel = SEL_TMR;
                IDX_AUX:  sel = SEL_AUX;
                IDX_ID:   sel = SEL_ID;
                IDX_MPIO: sel = SEL_MPIO;
                default:  sel = SEL_NONE;
            endcase
        end
        wr_strb = (req_valid && req_write && sel != SEL_NONE) ? ~req_be_n : '0;
        rd_en   = req_valid && !req_write;
    end
endmodule

// File: rtl/uglb_rdmux.sv
module uglb_rdmux
    import uglb_pkg::*;
(
    input  dw_sel_e         sel,
    input  logic [NB-1:0]   be_n,
    input  logic [N_CH-1:0] chan_irq,
    input  logic [7:0]      tmr_ctrl,
    input  logic [15:0]     tmr_reload,
    input  logic [N_CH-1:0] x8,
    input  logic [N_CH-1:0] sleep,
    output logic [DW-1:0]   rdata
);
    localparam int unsigned PAD = 8 - N_CH;

    logic [NB-1:0][7:0] raw;

    always_comb begin
        raw = '0;
        unique case (sel)
            SEL_IRQ: raw[0] = {{PAD{1'b0}}, chan_irq};
            SEL_TMR: begin
                raw[0] = tmr_ctrl;
                raw[2] = tmr_reload[7:0];
                raw[3] = tmr_reload[15:8];
            end
            SEL_AUX: begin
                raw[0] = {{PAD{1'b0}}, x8};
                raw[3] = {{PAD{1'b0}}, sleep};
            end
            SEL_ID: begin
                raw[0] = REV_BYTE;
                raw[1] = DEVID_BYTE;
            end
            default: raw = '0;
        endcase
    end

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign rdata[8*k +: 8] = be_n[k] ? 8'h00 : raw[k];
    end
endmodule

// File: rtl/uglb_regs.sv
module uglb_regs
    import uglb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [7:0]    req_addr,
    input  logic [3:0]    req_be_n,
    input  logic [31:0]   req_wdata,
    output logic [31:0]   rsp_rdata,
    input  logic [3:0]    chan_irq_i,
    output logic          irq_any_o,
    output logic [7:0]    timer_ctrl_o,
    output logic [15:0]   timer_reload_o,
    output logic [3:0]    x8_mode_o,
    output logic [3:0]    sleep_o,
    output logic [3:0]    chan_rst_o,
    output logic [7:0]    aux_ctrl_o
);
    localparam int unsigned LANE_RST   = 2;
    localparam int unsigned LANE_SLEEP = 3;
    localparam int unsigned LANE_WO    = 2;

    dw_sel_e       sel;
    logic [NB-1:0] wr_strb;
    logic          rd_en;
    logic [DW-1:0] rd_mux;
    regs_t         r_d, r_q;

    uglb_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be_n  (req_be_n),
        .sel       (sel),
        .wr_strb   (wr_strb),
        .rd_en     (rd_en)
    );

    uglb_rdmux u_rmux (
        .sel        (sel),
        .be_n       (req_be_n),
        .chan_irq   (chan_irq_i),
        .tmr_ctrl   (r_q.tmr_ctrl),
        .tmr_reload (r_q.tmr_reload),
        .x8         (r_q.x8),
        .sleep      (r_q.sleep),
        .rdata      (rd_mux)
    );

    always_comb begin
        r_d       = r_q;
        r_d.chrst = '0;
        unique case (sel)
            SEL_TMR: begin
                if (wr_strb[0]) r_d.tmr_ctrl         = req_wdata[7:0];
                if (wr_strb[2]) r_d.tmr_reload[7:0]  = req_wdata[23:16];
                if (wr_strb[3]) r_d.tmr_reload[15:8] = req_wdata[31:24];
            end
            SEL_AUX: begin
                if (wr_strb[0])          r_d.x8    = req_wdata[N_CH-1:0];
                if (wr_strb[LANE_RST])   r_d.chrst = req_wdata[8*LANE_RST +: N_CH];
                if (wr_strb[LANE_SLEEP]) r_d.sleep = req_wdata[8*LANE_SLEEP +: N_CH];
            end
            SEL_ID: begin
                if (wr_strb[LANE_WO]) r_d.wo_ctrl = req_wdata[8*LANE_WO +: 8];
            end
            default: ;
        endcase
        r_d.irq_any = |chan_irq_i;
        r_d.rdata   = rd_en ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_rdata      = r_q.rdata;
    assign irq_any_o      = r_q.irq_any;
    assign timer_ctrl_o   = r_q.tmr_ctrl;
    assign timer_reload_o = r_q.tmr_reload;
    assign x8_mode_o      = r_q.x8;
    assign sleep_o        = r_q.sleep;
    assign chan_rst_o     = r_q.chrst;
    assign aux_ctrl_o     = r_q.wo_ctrl;
endmodule

// File: rtl/uglb_regs_chk.sv
module uglb_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_addr,
    input logic [3:0]  req_be_n,
    input logic [31:0] rsp_rdata,
    input logic [3:0]  chan_irq_i,
    input logic        irq_any_o,
    input logic [15:0] timer_reload_o,
    input logic [3:0]  sleep_o,
    input logic [3:0]  chan_rst_o
);
    logic wr_aux, wr_tmr, rd_id;

    always_comb begin
        wr_aux = req_valid && req_write && (req_addr == 8'h88);
        wr_tmr = req_valid && req_write && (req_addr == 8'h84);
        rd_id  = req_valid && !req_write && (req_addr == 8'h8C) && !req_be_n[0];
    end

    assert_irq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_irq_i) |=> irq_any_o);

    assert_irq_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|chan_irq_i) |=> !irq_any_o);

    assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_rst_o != 4'h0) && !(wr_aux && !req_be_n[2])) |=> (chan_rst_o == 4'h0));

    assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_aux && !req_be_n[2])) |=> (chan_rst_o == 4'h0));

    assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_aux && !req_be_n[3]) |=> $stable(sleep_o));

    assert_reload_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_tmr && !(req_be_n[2] && req_be_n[3])) |=> $stable(timer_reload_o));

    assert_rev_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id |=> (rsp_rdata[7:0] == 8'h02));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (rsp_rdata == 32'h0));
endmodule

bind uglb_regs uglb_regs_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_be_n       (req_be_n),
    .rsp_rdata      (rsp_rdata),
    .chan_irq_i     (chan_irq_i),
    .irq_any_o      (irq_any_o),
    .timer_reload_o (timer_reload_o),
    .sleep_o        (sleep_o),
    .chan_rst_o     (chan_rst_o)
);

// File: tb/uglb_regs_test.sv
module uglb_regs_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  ben;
        logic [31:0] wd;
        logic [3:0]  irq;
        logic [31:0] exp;
    } vec_t;

    localparam int N_VEC = 20;
    localparam vec_t VEC [N_VEC] = '{
        '{1'b0, 8'h80, 4'h0, 32'h0,          4'b0101, 32'h0000_0005},
        '{1'b0, 8'h80, 4'h0, 32'h0,          4'b1010, 32'h0000_000A},
        '{1'b1, 8'h84, 4'h0, 32'hBEEF_CC5A,  4'b0000, 32'h0},
        '{1'b0, 8'h84, 4'h0, 32'h0,          4'b0000, 32'hBEEF_005A},
        '{1'b1, 8'h84, 4'hB, 32'h1177_2233,  4'b0000, 32'h0},
        '{1'b0, 8'h84, 4'h0, 32'h0,          4'b0000, 32'hBE77_005A},
        '{1'b0, 8'h84, 4'h7, 32'h0,          4'b0000, 32'hBE00_0000},
        '{1'b1, 8'h88, 4'h0, 32'hFF00_FFFF,  4'b0000, 32'h0},
        '{1'b0, 8'h88, 4'h0, 32'h0,          4'b0000, 32'h0F00_000F},
        '{1'b1, 8'h88, 4'h7, 32'h0500_0000,  4'b0000, 32'h0},
        '{1'b0, 8'h88, 4'h0, 32'h0,          4'b0000, 32'h0500_000F},
        '{1'b1, 8'h8C, 4'h0, 32'hFFFF_FFFF,  4'b0000, 32'h0},
        '{1'b0, 8'h8C, 4'h0, 32'h0,          4'b0000, 32'h0000_2402},
        '{1'b0, 8'h90, 4'h0, 32'h0,          4'b0000, 32'h0},
        '{1'b1, 8'h80, 4'h0, 32'hFFFF_FFFF,  4'b0000, 32'h0},
        '{1'b0, 8'h80, 4'h0, 32'h0,          4'b0000, 32'h0},
        '{1'b0, 8'h00, 4'h0, 32'h0,          4'b0000, 32'h0},
        '{1'b1, 8'h40, 4'h0, 32'h1234_5678,  4'b0000, 32'h0},
        '{1'b1, 8'h85, 4'h0, 32'h1234_5678,  4'b0000, 32'h0},
        '{1'b0, 8'h84, 4'h0, 32'h0,          4'b0000, 32'hBE77_005A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_be_n = 4'hF;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [3:0]  chan_irq_i = '0;
    logic        irq_any_o;
    logic [7:0]  timer_ctrl_o;
    logic [15:0] timer_reload_o;
    logic [3:0]  x8_mode_o;
    logic [3:0]  sleep_o;
    logic [3:0]  chan_rst_o;
    logic [7:0]  aux_ctrl_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    uglb_regs uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_be_n       (req_be_n),
        .req_wdata      (req_wdata),
        .rsp_rdata      (rsp_rdata),
        .chan_irq_i     (chan_irq_i),
        .irq_any_o      (irq_any_o),
        .timer_ctrl_o   (timer_ctrl_o),
        .timer_reload_o (timer_reload_o),
        .x8_mode_o      (x8_mode_o),
        .sleep_o        (sleep_o),
        .chan_rst_o     (chan_rst_o),
        .aux_ctrl_o     (aux_ctrl_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the request removed.
    task automatic access(input logic wr, input logic [7:0] addr, input logic [3:0] ben,
                          input logic [31:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_be_n  = ben;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_be_n  = 4'hF;
        req_wdata = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 timer_ctrl", {24'h0, timer_ctrl_o}, 32'h0);
        check("R1 timer_reload", {16'h0, timer_reload_o}, 32'h0);
        check("R1 x8/sleep/rst", {20'h0, x8_mode_o, sleep_o, chan_rst_o}, 32'h0);
        check("R1 aux_ctrl/irq_any", {23'h0, aux_ctrl_o, irq_any_o}, 32'h0);
        access(1'b0, 8'h8C, 4'h0, 32'h0);
        check("R1 rev/id read", rsp_rdata, 32'h0000_2402);
        access(1'b0, 8'h88, 4'h0, 32'h0);
        check("R1 aux dword read", rsp_rdata, 32'h0);

        // R2 R4 R5 R6 R8 R9 R10 R11: vector table; writes expect 0 read data
        for (int i = 0; i < N_VEC; i++) begin
            chan_irq_i = VEC[i].irq;
            access(VEC[i].wr, VEC[i].addr, VEC[i].ben, VEC[i].wd);
            check($sformatf("R2/R4/R5/R6/R8/R9/R10/R11 vec%0d", i), rsp_rdata, VEC[i].exp);
        end
        chan_irq_i = '0;

        // R4 outputs after table writes
        check("R4 timer_ctrl_o", {24'h0, timer_ctrl_o}, 32'h5A);
        check("R4 timer_reload_o", {16'h0, timer_reload_o}, 32'hBE77);
        check("R6 x8_mode_o", {28'h0, x8_mode_o}, 32'hF);
        check("R8 sleep_o", {28'h0, sleep_o}, 32'h5);
        check("R9 aux_ctrl_o", {24'h0, aux_ctrl_o}, 32'hFF);

        // R7: reset pulse lasts one cycle, other registers untouched, lane reads 0
        access(1'b1, 8'h88, 4'hB, 32'h0009_0000);
        check("R7 pulse high", {28'h0, chan_rst_o}, 32'h9);
        check("R7 sleep untouched", {24'h0, sleep_o, x8_mode_o}, 32'h5F);
        @(negedge clk);
        check("R7 pulse cleared", {28'h0, chan_rst_o}, 32'h0);
        access(1'b0, 8'h88, 4'hB, 32'h0);
        check("R7 reset lane reads 0", rsp_rdata, 32'h0);
        check("R7 no pulse on read", {28'h0, chan_rst_o}, 32'h0);
        access(1'b1, 8'h88, 4'hB, 32'h0006_0000);
        access(1'b1, 8'h88, 4'hB, 32'h0001_0000);
        check("R7 back-to-back second pulse", {28'h0, chan_rst_o}, 32'h1);
        @(negedge clk);
        check("R7 back-to-back cleared", {28'h0, chan_rst_o}, 32'h0);

        // R3: combined interrupt, registered once
        chan_irq_i = 4'b1000;
        #1;
        check("R3 not before edge", {31'h0, irq_any_o}, 32'h0);
        @(negedge clk);
        check("R3 set after edge", {31'h0, irq_any_o}, 32'h1);
        chan_irq_i = 4'b0000;
        @(negedge clk);
        check("R3 clear after edge", {31'h0, irq_any_o}, 32'h0);

        // R5: single lane write to sleep leaves x8 alone
        access(1'b1, 8'h88, 4'h7, 32'h0A00_0000);
        access(1'b0, 8'h88, 4'h0, 32'h0);
        check("R5 lane3-only write", rsp_rdata, 32'h0A00_000F);

        // R1: reset mid-run returns all state to reset values
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 re-reset sleep/x8", {24'h0, sleep_o, x8_mode_o}, 32'h0);
        check("R1 re-reset timer", {8'h0, timer_ctrl_o, timer_reload_o}, 32'h0);
        check("R1 re-reset aux", {24'h0, aux_ctrl_o}, 32'h0);

        finish_run();
    end
endmodule